// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block turns a deferred flag record into the five condition code bits X, N, Z, V and C. An execution unit does not compute flags on every instruction. It leaves behind a record instead: an operation class, an operand size, and a few stored words. Consumers of the flags read the packed condition code output, and the block works the flags out from that record.

For add and subtract, the first operand is not stored. It is rebuilt from the stored result and the stored second operand, then sign-extended to the operation size. A flush request rewrites the record into its flags-already-valid form, so later reads need no arithmetic.

The block has two write ports. The condition-code write port loads the five flags directly. The status-word write port also keeps the upper system bits. The record inputs are loaded through a plain write strobe.

Top module: `lazy_ccr`

## Requirements
- R1: After reset, ccr_o reads 0, sr_o reads 0, rec_class_o reads 0 and err_o is low.
- R2: Class 1 (add) stores the result in rec_n, the second operand in rec_v and the carry in rec_x. One cycle after the record is loaded, ccr_o gives the flags as follows.
  - X and C both equal the carry.
  - N is the sign of the result at the operand size.
  - Z is set when the result is zero.
  - V is the signed overflow of the addition.
  - Sizes are encoded 0 = byte, 1 = word, and 2 or 3 = long.
  - ccr_o packs the flags as X in bit 4, N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R3: Class 2 (subtract) uses the same record layout as add, with rec_x holding the borrow. X and C equal the borrow, and V is the signed overflow of the first operand minus the second.
- R4: Class 3 (compare) stores the first operand in rec_n and the second in rec_v. N and Z come from their difference at the operand size. C is set when the first operand is unsigned-below the second. V is the signed overflow of the difference. X keeps the stored rec_x.
- R5: Class 4 (logic) clears V and C. N is rec_n bit 31, Z is set when rec_n is zero, and X is rec_x.
- R6: Class 0 (flags valid) reads the flags straight from the record: X = rec_x, N = rec_n bit 31, Z is set when rec_z is zero, V = rec_v bit 31, C = rec_c.
- R7: A condition-code write sets the class to 0, and two cycles later ccr_o equals the written five bits.
- R8: A status-word write keeps bits 15:5 and shows them on sr_o[15:5]. Its bits 4:0 load the condition codes, as a condition-code write does. The lower half of sr_o mirrors ccr_o.
- R9: A flush with a valid class sets rec_class_o to 0 and leaves ccr_o unchanged.
- R10: A class of 5, 6 or 7 raises err_o. While it stays loaded, ccr_o keeps its previous value and a flush has no effect.
- R11: Port priority runs status-word write first, then condition-code write, then record write, then flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rec_we | input | 1 | Load the record inputs |
| rec_class | input | 3 | Operation class |
| rec_size | input | 2 | Operand size |
| rec_x | input | 1 | Stored extend or carry |
| rec_n | input | W | Stored result or first operand |
| rec_z | input | W | Stored zero word |
| rec_v | input | W | Stored second operand or overflow word |
| rec_c | input | 1 | Stored carry |
| ccr_we | input | 1 | Condition-code write strobe |
| ccr_wdata | input | 5 | Condition-code write value |
| sr_we | input | 1 | Status-word write strobe |
| sr_wdata | input | 16 | Status-word write value |
| flush_i | input | 1 | Rewrite the record into flags-valid form |
| ccr_o | output | 5 | Packed condition code |
| sr_o | output | 16 | System bits above the condition code |
| rec_class_o | output | 3 | Current record class |
| err_o | output | 1 | Current class is unrecognised |

## Verification
The assertions assume the record is self-consistent. For add and subtract, rec_n and rec_v must be the result and second operand sign-extended from the operation size. For compare, the operands must be sign-extended the same way. The bench builds every record from true operand pairs with its own arithmetic, so this holds. The byte size is swept over a dense grid, and word and long use corner values around zero, the sign boundary and all-ones.

// File: rtl/lazy_ccr.sv
module lazy_ccr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rec_we,
  input  logic [2:0]   rec_class,
  input  logic [1:0]   rec_size,
  input  logic         rec_x,
  input  logic [W-1:0] rec_n,
  input  logic [W-1:0] rec_z,
  input  logic [W-1:0] rec_v,
  input  logic         rec_c,
  input  logic         ccr_we,
  input  logic [4:0]   ccr_wdata,
  input  logic         sr_we,
  input  logic [15:0]  sr_wdata,
  input  logic         flush_i,
  output logic [4:0]   ccr_o,
  output logic [15:0]  sr_o,
  output logic [2:0]   rec_class_o,
  output logic         err_o
);
  localparam int SB = W - 1;

  logic [2:0]   cls_q;
  logic [1:0]   sz_q;
  logic         x_q, c_q;
  logic [W-1:0] n_q, z_q, v_q;
  logic [10:0]  sys_q;
  logic [4:0]   ccr_q;

  logic [W-1:0] s1, s2, rs, nw, zw, vw;
  logic         cf, bad;
  logic [4:0]   eval;
  logic [4:0]   wcc;

  function automatic logic [W-1:0] sx(input logic [W-1:0] val, input logic [1:0] sz);
    case (sz)
      2'd0:    sx = {{(W-8){val[7]}}, val[7:0]};
      2'd1:    sx = {{(W-16){val[15]}}, val[15:0]};
      default: sx = val;
    endcase
  endfunction

  always_comb begin
    s1 = '0; s2 = '0; rs = '0;
    nw = n_q; zw = z_q; vw = v_q; cf = c_q; bad = 1'b0;
    case (cls_q)
      3'd0: ;
      3'd1: begin
        rs = n_q; s2 = v_q; s1 = sx(rs - s2, sz_q);
        cf = x_q; zw = n_q; vw = (rs ^ s1) & ~(s1 ^ s2);
      end
      3'd2: begin
        rs = n_q; s2 = v_q; s1 = sx(rs + s2, sz_q);
        cf = x_q; zw = n_q; vw = (rs ^ s1) & (s1 ^ s2);
      end
      3'd3: begin
        s1 = n_q; s2 = v_q; rs = sx(s1 - s2, sz_q);
        nw = rs; zw = rs; cf = s1 < s2; vw = (rs ^ s1) & (s1 ^ s2);
      end
      3'd4: begin
        cf = 1'b0; vw = '0; zw = n_q;
      end
      default: bad = 1'b1;
    endcase
  end

  assign eval = {x_q, nw[SB], zw == '0, vw[SB], cf};
  assign wcc  = sr_we ? sr_wdata[4:0] : ccr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= 3'd0; sz_q <= 2'd0; x_q <= 1'b0; c_q <= 1'b0;
      n_q <= '0; z_q <= {{(W-1){1'b0}}, 1'b1}; v_q <= '0;
      sys_q <= '0; ccr_q <= '0;
    end else begin
      if (sr_we) sys_q <= sr_wdata[15:5];
      if (sr_we || ccr_we) begin
        cls_q <= 3'd0;
        x_q <= wcc[4]; n_q <= {W{wcc[3]}};
        z_q <= {{(W-1){1'b0}}, ~wcc[2]};
        v_q <= {W{wcc[1]}}; c_q <= wcc[0];
      end else if (rec_we) begin
        cls_q <= rec_class; sz_q <= rec_size;
        x_q <= rec_x; n_q <= rec_n; z_q <= rec_z; v_q <= rec_v; c_q <= rec_c;
      end else if (flush_i && !bad) begin
        cls_q <= 3'd0;
        x_q <= eval[4]; n_q <= {W{eval[3]}};
        z_q <= {{(W-1){1'b0}}, ~eval[2]};
        v_q <= {W{eval[1]}}; c_q <= eval[0];
      end
      if (!bad) ccr_q <= eval;
    end
  end

  assign ccr_o       = ccr_q;
  assign sr_o        = {sys_q, ccr_q};
  assign rec_class_o = cls_q;
  assign err_o       = bad;

  a_r10_hold_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> $stable(ccr_o));
  a_r9_flush_class: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !err_o && !rec_we && !ccr_we && !sr_we) |=> rec_class_o == 3'd0);
  a_r5_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rec_class_o == 3'd4 |=> ccr_o[1:0] == 2'b00);
  a_r7_ccr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_we && !sr_we) |=> ##1 (ccr_o == $past(ccr_wdata, 2)));
  a_r8_sys_bits: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> sr_o[15:5] == $past(sr_wdata[15:5]));
endmodule

// File: tb/lazy_ccr_tb.sv
module lazy_ccr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_we = 0, rec_x = 0, rec_c = 0, ccr_we = 0, sr_we = 0, flush_i = 0;
  logic [2:0] rec_class = 0;
  logic [1:0] rec_size = 0;
  logic [31:0] rec_n = 0, rec_z = 0, rec_v = 0;
  logic [4:0] ccr_wdata = 0;
  logic [15:0] sr_wdata = 0;
  logic [4:0] ccr_o;
  logic [15:0] sr_o;
  logic [2:0] rec_class_o;
  logic err_o;
  int nchk = 0, nfail = 0;

  lazy_ccr u_dut (.clk(clk), .rst_n(rst_n), .rec_we(rec_we), .rec_class(rec_class),
    .rec_size(rec_size), .rec_x(rec_x), .rec_n(rec_n), .rec_z(rec_z), .rec_v(rec_v),
    .rec_c(rec_c), .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .flush_i(flush_i), .ccr_o(ccr_o), .sr_o(sr_o),
    .rec_class_o(rec_class_o), .err_o(err_o));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int sz);
    return sz == 0 ? 32'hff : sz == 1 ? 32'hffff : 32'hffffffff;
  endfunction
  function automatic int sgn(input int sz);
    return sz == 0 ? 7 : sz == 1 ? 15 : 31;
  endfunction
  function automatic logic [31:0] ext(input logic [31:0] a, input int sz);
    logic [31:0] r = a & msk(sz);
    if (r[sgn(sz)]) r = r | ~msk(sz);
    return r;
  endfunction
  function automatic logic [31:0] corner(input int sz, input int k);
    logic [31:0] m = msk(sz), h = m ^ (m >> 1);
    case (k)
      0: return 0; 1: return 1; 2: return 2; 3: return h - 1;
      4: return h; 5: return h + 1; 6: return m - 1; 7: return m;
      8: return 32'h5a5a5a5a & m; default: return 32'hc3c3c3c3 & m;
    endcase
  endfunction

  task automatic load(input logic [2:0] cl, input int sz, input logic x,
                      input logic [31:0] n, input logic [31:0] z, input logic [31:0] v, input logic c);
    @(negedge clk);
    rec_class = cl; rec_size = sz[1:0]; rec_x = x; rec_n = n; rec_z = z; rec_v = v; rec_c = c;
    rec_we = 1;
    @(negedge clk); rec_we = 0;
    @(negedge clk);
  endtask

  task automatic run_arith(input int op, input int sz, input logic [31:0] a0, input logic [31:0] b0, input logic xin);
    logic [31:0] m = msk(sz), a = a0 & m, b = b0 & m, r;
    logic [32:0] full;
    logic cy, nf, zf, vf;
    int sp = sgn(sz);
    if (op == 1) begin
      full = {1'b0, a} + {1'b0, b}; r = full[31:0] & m;
      cy = full > {1'b0, m};
      vf = (a[sp] == b[sp]) && (r[sp] != a[sp]);
      nf = r[sp]; zf = (r == 0);
      load(3'd1, sz, cy, ext(r, sz), 32'h0, ext(b, sz), 1'b0);
      chk($sformatf("R2 add sz%0d %h+%h", sz, a, b), ccr_o, {cy, nf, zf, vf, cy});
    end else if (op == 2) begin
      r = (a - b) & m; cy = a < b;
      vf = (a[sp] != b[sp]) && (r[sp] != a[sp]);
      nf = r[sp]; zf = (r == 0);
      load(3'd2, sz, cy, ext(r, sz), 32'h0, ext(b, sz), 1'b0);
      chk($sformatf("R3 sub sz%0d %h-%h", sz, a, b), ccr_o, {cy, nf, zf, vf, cy});
    end else begin
      r = (a - b) & m; cy = a < b;
      vf = (a[sp] != b[sp]) && (r[sp] != a[sp]);
      nf = r[sp]; zf = (r == 0);
      load(3'd3, sz, xin, ext(a, sz), 32'h0, ext(b, sz), 1'b0);
      chk($sformatf("R4 cmp sz%0d %h,%h", sz, a, b), ccr_o, {xin, nf, zf, vf, cy});
    end
  endtask

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [4:0] c0;
    repeat (3) @(negedge clk);
    chk("R1 reset ccr", ccr_o, 0);
    chk("R1 reset sr", sr_o, 0);
    chk("R1 reset class", rec_class_o, 0);
    chk("R1 reset err", err_o, 0);
    rst_n = 1;

    for (int op = 1; op <= 3; op++)
      for (int a = 0; a < 256; a += 3)
        for (int b = 0; b < 256; b += 3)
          run_arith(op, 0, a, b, a[0] ^ b[1]);
    for (int sz = 1; sz <= 2; sz++)
      for (int op = 1; op <= 3; op++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            run_arith(op, sz, corner(sz, i), corner(sz, j), i[0]);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] n = k[0] ? 32'h0 : (k[1] ? 32'h80000001 : 32'h00000040);
      load(3'd4, k % 3, k[2], n, 32'h0, 32'hffffffff, 1'b1);
      chk("R5 logic", ccr_o, {k[2], n[31], n == 0, 2'b00});
    end

    for (int k = 0; k < 32; k++) begin
      logic [31:0] n = k[0] ? 32'h80000000 : 32'h7fffffff;
      logic [31:0] z = k[1] ? 32'h0 : 32'h00010000;
      logic [31:0] v = k[2] ? 32'hc0000000 : 32'h40000000;
      load(3'd0, 2, k[3], n, z, v, k[4]);
      chk("R6 flags form", ccr_o, {k[3], n[31], z == 0, v[31], k[4]});
    end

    for (int k = 0; k < 32; k++) begin
      @(negedge clk); ccr_wdata = k[4:0]; ccr_we = 1;
      @(negedge clk); ccr_we = 0;
      @(negedge clk);
      chk("R7 ccr write", ccr_o, k);
      chk("R7 class", rec_class_o, 0);
    end

    @(negedge clk); sr_wdata = 16'ha5f3; sr_we = 1;
    @(negedge clk); sr_we = 0;
    @(negedge clk);
    chk("R8 sr write", sr_o, 16'ha5f3);

    run_arith(1, 0, 8'h7f, 8'h01, 0);
    c0 = ccr_o;
    @(negedge clk); flush_i = 1;
    @(negedge clk); flush_i = 0;
    @(negedge clk);
    chk("R9 flush class", rec_class_o, 0);
    chk("R9 flush ccr", ccr_o, c0);
    run_arith(3, 1, 16'h0001, 16'h8000, 1);
    c0 = ccr_o;
    @(negedge clk); flush_i = 1;
    @(negedge clk); flush_i = 0;
    @(negedge clk);
    chk("R9 flush cmp class", rec_class_o, 0);
    chk("R9 flush cmp ccr", ccr_o, c0);

    for (int cl = 5; cl <= 7; cl++) begin
      load(3'(cl), 2, 1'b1, 32'h0, 32'h0, 32'hffffffff, 1'b1);
      chk("R10 err", err_o, 1);
      chk("R10 hold", ccr_o, c0);
      @(negedge clk); flush_i = 1;
      @(negedge clk); flush_i = 0;
      @(negedge clk);
      chk("R10 flush ignored", rec_class_o, cl);
      chk("R10 hold after flush", ccr_o, c0);
    end

    @(negedge clk);
    rec_class = 3'd4; rec_n = 32'h0; rec_x = 1; rec_we = 1;
    ccr_wdata = 5'b01011; ccr_we = 1;
    @(negedge clk); rec_we = 0; ccr_we = 0;
    @(negedge clk);
    chk("R11 ccr beats record", ccr_o, 5'b01011);
    chk("R11 class", rec_class_o, 0);
    chk("R11 err clear", err_o, 0);
    @(negedge clk);
    ccr_wdata = 5'b11111; ccr_we = 1; sr_wdata = 16'h0024; sr_we = 1;
    @(negedge clk); ccr_we = 0; sr_we = 0;
    @(negedge clk);
    chk("R11 sr beats ccr", sr_o, 16'h0024);
    @(negedge clk);
    rec_class = 3'd4; rec_n = 32'h1; rec_x = 0; rec_we = 1; flush_i = 1;
    @(negedge clk); rec_we = 0; flush_i = 0;
    @(negedge clk);
    chk("R11 record beats flush", rec_class_o, 4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule